// File: doc/BRIEF.md
# Cascaded PWM Channel Run Controller

This block decides, cycle by cycle, which of a row of cascaded PWM generator channels may count. Each channel has a software run request, a follow-upstream (autorun) selector, a graceful-stop selector and an end-of-cycle pulse from its own period counter. The block returns one registered run-enable per channel. That enable gates the channel's waveform counter and also serves as the channel's readable run status.

The run requests form a chain. A channel with autorun set runs whenever the channel before it is requested to run. That upstream channel may itself be following the one before it. A channel's own run bit always wins over its autorun setting. When a run request goes away, the channel stops on the next edge, except in one case. If graceful stop is selected and the channel is not a follower, it keeps running until its counter reports the end of the current waveform cycle.

Top module: `pwm_run_chain`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `run_en` is 0 after that edge.
- R2: When `run_bit[i]` is 1 at a clock edge, `run_en[i]` is 1 after that edge.
- R3: For a channel i > 0 with `auto_bit[i]` = 1, the channel is requested whenever channel i-1 is requested. The request passes down the whole chain within one cycle, so all the followers start on the same edge as the head channel.
- R4: A channel whose own `run_bit` is 1 runs even when its `auto_bit` is 1 and its upstream channel is idle.
- R5: `auto_bit[0]` has no effect. Channel 0 runs only on `run_bit[0]`.
- R6: With `cmpl_bit[i]` = 0, `run_en[i]` is 0 on the first edge at which channel i has no request.
- R7: With `cmpl_bit[i]` = 1 and channel i not a follower, a running channel with no request stays enabled until an edge at which `cycle_end[i]` is 1. It is 0 after that edge. The end-of-cycle pulse of another channel has no effect on it.
- R8: A follower channel (i > 0, `auto_bit[i]` = 1) ignores `cmpl_bit[i]` and stops on the first edge at which it has no request.
- R9: A pending graceful stop is cancelled if the request returns before the end-of-cycle pulse. A `cycle_end` pulse in the same cycle as the returned request does not stop the channel.
- R10: A `cycle_end` pulse while the channel is requested leaves `run_en` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_bit | input | NUM_CH | Software run request per channel |
| auto_bit | input | NUM_CH | Follow-upstream selector per channel (ignored for channel 0) |
| cmpl_bit | input | NUM_CH | Graceful stop selector per channel |
| cycle_end | input | NUM_CH | One-cycle end-of-waveform pulse from each channel's counter |
| run_en | output | NUM_CH | Registered run enable / run status per channel |

## Verification
Two events can land on one edge: the end-of-cycle pulse that completes a graceful stop, and the return of the run request that cancels that stop. The bench drives both in the same cycle while channel 1 is draining, and expects the channel to stay enabled. It then withdraws the request again and expects the drain to start over. The channel must drop only on a later pulse that arrives while no request is present. A request being withdrawn in the same cycle as a pulse is checked separately, and the channel must stop at once.

// File: rtl/pwm_run_pkg.sv
package pwm_run_pkg;

    // Per-channel control bundle as seen by one run slot
    typedef struct packed {
        logic req;       // effective run request after chaining
        logic follower;  // channel is slaved to its upstream neighbour
        logic graceful;  // finish the waveform cycle before halting
        logic cyc_end;   // end-of-cycle pulse from the period counter
    } slot_ctl_t;

    typedef enum logic [1:0] {
        ACT_RUN  = 2'd0,
        ACT_HOLD = 2'd1,
        ACT_STOP = 2'd2
    } slot_act_e;

    // Decide what a slot does on the coming edge
    function automatic slot_act_e slot_decide(input slot_ctl_t c, input logic en);
        if (c.req)
            return ACT_RUN;
        else if (en && c.graceful && !c.follower && !c.cyc_end)
            return ACT_HOLD;
        else
            return ACT_STOP;
    endfunction

endpackage

// File: rtl/pwm_req_chain.sv
module pwm_req_chain #(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0] run_bit,
    input  logic [NUM_CH-1:0] auto_bit,
    output logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] follower
);

    // Head channel: no upstream, autorun is ignored
    assign req[0]      = run_bit[0];
    assign follower[0] = 1'b0;

    for (genvar i = 1; i < NUM_CH; i++) begin : g_link
        assign req[i]      = run_bit[i] | (auto_bit[i] & req[i-1]);
        assign follower[i] = auto_bit[i];
    end

endmodule

// File: rtl/pwm_run_slot.sv
module pwm_run_slot
    import pwm_run_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_ctl_t ctl,
    output logic      en
);

    slot_act_e act;

    always_comb act = slot_decide(ctl, en);

    always_ff @(posedge clk) begin
        if (rst)
            en <= 1'b0;
        else
            en <= (act != ACT_STOP);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !en);

    // R2
    req_start_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.req |=> en);

    // R6
    abrupt_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.req && !ctl.graceful) |=> !en);

    // R8
    follower_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.req && ctl.follower) |=> !en);

    // R7
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.req && en && ctl.graceful && !ctl.follower && !ctl.cyc_end) |=> en);

    // R7
    drain_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.req && ctl.cyc_end) |=> !en);

endmodule

// File: rtl/pwm_run_chain.sv
module pwm_run_chain
    import pwm_run_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] run_bit,
    input  logic [NUM_CH-1:0] auto_bit,
    input  logic [NUM_CH-1:0] cmpl_bit,
    input  logic [NUM_CH-1:0] cycle_end,
    output logic [NUM_CH-1:0] run_en
);

    logic      [NUM_CH-1:0] chain_req;
    logic      [NUM_CH-1:0] chain_fol;
    slot_ctl_t              ctl [NUM_CH];

    pwm_req_chain #(.NUM_CH(NUM_CH)) u_chain (
        .run_bit  (run_bit),
        .auto_bit (auto_bit),
        .req      (chain_req),
        .follower (chain_fol)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        always_comb begin
            ctl[i].req      = chain_req[i];
            ctl[i].follower = chain_fol[i];
            ctl[i].graceful = cmpl_bit[i];
            ctl[i].cyc_end  = cycle_end[i];
        end

        pwm_run_slot u_slot (
            .clk (clk),
            .rst (rst),
            .ctl (ctl[i]),
            .en  (run_en[i])
        );
    end

    // Port-level view of the cascade: a follower tracks its upstream request
    for (genvar i = 1; i < NUM_CH; i++) begin : g_casc_chk
        // R3
        follow_start_chk: assert property (@(posedge clk) disable iff (rst)
            (auto_bit[i] && chain_req[i-1]) |=> run_en[i]);

        // R4
        own_run_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (run_bit[i] && auto_bit[i]) |=> run_en[i]);
    end

    // R5
    head_auto_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_bit[0] && !run_en[0]) |=> !run_en[0]);

endmodule

// File: tb/pwm_run_chain_test.sv
module pwm_run_chain_test;

    localparam int N  = 3;
    localparam int NV = 23;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] run_bit, auto_bit, cmpl_bit, cycle_end;
    logic [N-1:0] run_en;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_run_chain #(.NUM_CH(N)) uut (
        .clk       (clk),
        .rst       (rst),
        .run_bit   (run_bit),
        .auto_bit  (auto_bit),
        .cmpl_bit  (cmpl_bit),
        .cycle_end (cycle_end),
        .run_en    (run_en)
    );

    // {tag, run, auto, cmpl, cyc_end, expected run_en}; bit i = channel i
    localparam logic [18:0] VEC [NV] = '{
        {4'd2,  3'b001, 3'b000, 3'b000, 3'b000, 3'b001},  // R2 head starts
        {4'd3,  3'b001, 3'b110, 3'b000, 3'b000, 3'b111},  // R3 cascade
        {4'd6,  3'b000, 3'b110, 3'b000, 3'b000, 3'b000},  // R6 abrupt stop
        {4'd3,  3'b001, 3'b110, 3'b111, 3'b000, 3'b111},  // R3 restart
        {4'd8,  3'b000, 3'b110, 3'b111, 3'b000, 3'b001},  // R8 followers drop
        {4'd7,  3'b000, 3'b110, 3'b111, 3'b000, 3'b001},  // R7 head drains
        {4'd7,  3'b000, 3'b110, 3'b111, 3'b001, 3'b000},  // R7 pulse ends it
        {4'd5,  3'b010, 3'b001, 3'b000, 3'b000, 3'b010},  // R5 head autorun
        {4'd4,  3'b010, 3'b011, 3'b000, 3'b000, 3'b010},  // R4 own run wins
        {4'd7,  3'b000, 3'b000, 3'b010, 3'b000, 3'b010},  // R7 ch1 drains
        {4'd9,  3'b010, 3'b000, 3'b010, 3'b010, 3'b010},  // R9 re-request + pulse
        {4'd9,  3'b000, 3'b000, 3'b010, 3'b000, 3'b010},  // R9 drain restarts
        {4'd7,  3'b000, 3'b000, 3'b010, 3'b010, 3'b000},  // R7 drop on pulse
        {4'd10, 3'b001, 3'b000, 3'b001, 3'b001, 3'b001},  // R10
        {4'd10, 3'b001, 3'b000, 3'b001, 3'b001, 3'b001},  // R10
        {4'd4,  3'b010, 3'b010, 3'b010, 3'b000, 3'b010},  // R4 ch1 own run
        {4'd8,  3'b000, 3'b010, 3'b010, 3'b000, 3'b000},  // R8 cmpl ignored
        {4'd2,  3'b100, 3'b000, 3'b100, 3'b000, 3'b100},  // R2 tail starts
        {4'd7,  3'b000, 3'b000, 3'b100, 3'b011, 3'b100},  // R7 foreign pulse
        {4'd7,  3'b000, 3'b000, 3'b100, 3'b100, 3'b000},  // R7 own pulse
        {4'd6,  3'b000, 3'b000, 3'b000, 3'b000, 3'b000},  // R6 idle stays
        {4'd2,  3'b100, 3'b000, 3'b000, 3'b000, 3'b100},  // R2
        {4'd6,  3'b000, 3'b000, 3'b000, 3'b100, 3'b000}   // R6
    };

    task automatic check(input logic [N-1:0] exp, input int tag);
        nchk++;
        if (run_en !== exp) begin
            nbad++;
            $display("FAIL R%0d: run_en=%b expected=%b", tag, run_en, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] r, input logic [N-1:0] a,
                         input logic [N-1:0] c, input logic [N-1:0] e,
                         input logic [N-1:0] exp, input int tag);
        @(negedge clk);
        run_bit = r; auto_bit = a; cmpl_bit = c; cycle_end = e;
        @(posedge clk);
        #1;
        check(exp, tag);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    endtask

    initial begin
        rst = 1'b1;
        run_bit = '0; auto_bit = '0; cmpl_bit = '0; cycle_end = '0;
        repeat (2) @(posedge clk);
        #1;
        check(3'b000, 1);  // R1 reset state
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++)
            apply(VEC[k][14:12], VEC[k][11:9], VEC[k][8:6], VEC[k][5:3],
                  VEC[k][2:0], int'(VEC[k][18:15]));

        // R1: reset while all channels run
        apply(3'b111, 3'b000, 3'b000, 3'b000, 3'b111, 2);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(3'b000, 1);  // R1 mid-run
        @(negedge clk);
        rst = 1'b0;
        run_bit = '0;

        // R7: long drain on channel 0, several idle cycles then pulse
        apply(3'b001, 3'b000, 3'b001, 3'b000, 3'b001, 2);
        for (int k = 0; k < 5; k++)
            apply(3'b000, 3'b000, 3'b001, 3'b000, 3'b001, 7);
        apply(3'b000, 3'b000, 3'b001, 3'b001, 3'b000, 7);

        // R9: cancel a drain by re-requesting, then stop abruptly
        apply(3'b001, 3'b000, 3'b001, 3'b000, 3'b001, 2);
        apply(3'b000, 3'b000, 3'b001, 3'b000, 3'b001, 7);
        apply(3'b001, 3'b000, 3'b001, 3'b000, 3'b001, 9);
        apply(3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 6);

        // R3: chain breaks in the middle, tail cannot follow
        apply(3'b001, 3'b100, 3'b000, 3'b000, 3'b001, 3);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: run_en=%b expected=finish", run_en);
            summary();
            $finish;
        end
    end

endmodule